// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one SMBus-style transaction at a time on top of a byte-level I2C master engine. The engine handles the bit timing on the wire. The sequencer decides, byte by byte, what the engine does next: issue a start, write a byte, set the acknowledge policy for the next received byte, or issue a stop. It moves forward one step for each byte-level event the engine reports. An event is one of: byte finished, bus error, negative acknowledge, or mastership lost.

A request carries a 7-bit target address, a direction flag, a command byte, a transaction kind and, for block transfers, a length. Bytes to write come in as a flat vector. Received bytes are stored in lanes of a flat output vector in arrival order. For kinds that carry a command byte, a read is carried out as follows:
- The command is written first.
- A repeated start follows.
- The address is sent again, this time with the read flag.

The acknowledge control looks one byte ahead, so the last received byte is negatively acknowledged. Every transaction ends with a one-cycle `done` pulse, a result code, and a flag asking for a controller reset. A programmable event timeout stops a transaction that has stalled.

Top module: `smbus_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `eng_start`, `eng_stop`, `eng_wr`, `eng_nack`, `done`, `reset_req` and `spurious` are all 0.
- R2: A request is taken only while `req_ready` is 1 and `req_valid` is 1. In the cycle after a legal request is taken, `eng_start` pulses and `req_ready` drops. Kind encodings: quick=0, byte=1, byte-data=2, word=3, block=4.
- R3: The following requests are rejected: a quick read, a block length of 0, a block length above MAX_LEN, or a kind code from 5 to 7. One cycle after a rejected request is taken, `done` pulses with result 3 (invalid). No start is issued and `req_ready` stays 1.
- R4: For kinds 2 to 4, the first byte-done writes the address byte with bit 0 cleared (`{addr,0}`), and the second writes the command. For a read, the third writes `{addr,1}` together with an `eng_start` pulse (repeated start).
- R5: For kinds 0 and 1, the first byte-done writes `{addr,rd}` with no start pulse.
- R6: When the read address is sent, `eng_nack` becomes 1 if exactly one byte will be received. At each received byte, `eng_nack` becomes 1 if exactly one further byte remains; otherwise it becomes 0.
- R7: Each byte-done in the read phase stores `eng_rdata` into the next lane of `rd_data`, starting at lane 0 (bits 7:0). For a word read, lane 0 holds the low byte. The last byte causes a stop pulse and `done` with result 0 (ok) in the same cycle.
- R8: In the write phase, each byte-done writes the next lane of `req_wdata`, starting at lane 0. A byte-kind write sends the command byte as its single data byte. The byte-done after the last data byte causes a stop and `done` with result 0.
- R9: A negative acknowledge in any active state pulses `eng_stop` and `done`, gives result 1 (no device) and leaves `reset_req` at 0.
- R10: A bus error, or a byte-done while `ev_master` is 0, gives `done` with result 2 (I/O error) and `reset_req` 1, and no stop pulse.
- R11: If no event arrives for `tmo_limit` cycles while busy, `done` pulses with result 2 and `reset_req` is 1. An event in the expiry cycle wins and restarts the count.
- R12: Events while idle cause no engine action. They set the sticky `spurious` flag, which only reset clears.
- R13: When a bus error and a negative acknowledge arrive together, the bus error wins: result 2, no stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 7 | Target address |
| req_rd | input | 1 | 1 = read transaction |
| req_cmd | input | 8 | Command byte |
| req_kind | input | 3 | Transaction kind code |
| req_len | input | 6 | Block length (kind 4 only) |
| req_wdata | input | 256 | Write data, lane 0 sent first |
| tmo_limit | input | 16 | Event timeout in cycles |
| ev_done | input | 1 | Engine byte step finished |
| ev_nack | input | 1 | Engine saw negative acknowledge |
| ev_berr | input | 1 | Engine saw bus error |
| ev_master | input | 1 | Engine still owns the bus |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_start | output | 1 | Start / repeated start strobe |
| eng_stop | output | 1 | Stop strobe |
| eng_nack | output | 1 | Negatively acknowledge next received byte |
| eng_wr | output | 1 | Write strobe for `eng_wdata` |
| eng_wdata | output | 8 | Byte for the engine to send |
| done | output | 1 | Transaction finished (one cycle) |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 invalid |
| reset_req | output | 1 | Controller reset wanted, valid with `done` |
| rd_data | output | 256 | Received bytes, lane 0 first |
| spurious | output | 1 | Sticky: an event arrived while idle |

## Verification
Two functions can fall in the same cycle: the expiry of the event timeout and the arrival of a byte-done. Both happen in the cycle that is exactly `tmo_limit` cycles after the previous step. The bench delivers a byte-done in exactly that cycle and expects three things: no `done`, the next protocol byte on `eng_wdata`, and a full new timeout window before the I/O error is reported. Randomly placed fault events also include a bus error that coincides with a negative acknowledge, where the error path must win.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  typedef enum logic [2:0] {
    K_QUICK = 3'd0, K_BYTE = 3'd1, K_BDATA = 3'd2, K_WORD = 3'd3, K_BLOCK = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_RSTART, S_QUICK, S_READ, S_WRITE
  } st_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_NODEV = 2'd1, RES_IOERR = 2'd2, RES_INVAL = 2'd3
  } res_e;
endpackage

// File: rtl/smbus_seq_req.sv
module smbus_seq_req
  import smbus_seq_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic [2:0]    kind,
  input  logic          rd,
  input  logic [LW-1:0] blen,
  output logic          legal,
  output logic [LW-1:0] xlen,
  output logic          via_quick
);
  // payload byte count implied by the kind
  function automatic logic [LW-1:0] kind_len(input logic [2:0] k, input logic [LW-1:0] b);
    case (k)
      3'(K_QUICK):             return '0;
      3'(K_BYTE), 3'(K_BDATA): return LW'(1);
      3'(K_WORD):              return LW'(2);
      default:                 return b;
    endcase
  endfunction

  function automatic logic kind_ok(input logic [2:0] k, input logic r, input logic [LW-1:0] b);
    if (k > 3'(K_BLOCK)) return 1'b0;
    if (k == 3'(K_BLOCK) && (b == '0 || b > LW'(MAX_LEN))) return 1'b0;
    if (r && kind_len(k, b) == '0) return 1'b0;
    return 1'b1;
  endfunction

  assign xlen      = kind_len(kind, blen);
  assign legal     = kind_ok(kind, rd, blen);
  assign via_quick = (kind == 3'(K_QUICK)) || (kind == 3'(K_BYTE));
endmodule

// File: rtl/smbus_seq_tmr.sv
module smbus_seq_tmr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = run && !kick && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || kick || expire) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smbus_seq_rbuf.sv
module smbus_seq_rbuf #(
  parameter int MAX_LEN = 32,
  localparam int IW = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  logic [7:0]           din,
  output logic [MAX_LEN*8-1:0] data
);
  logic [7:0] lane [MAX_LEN];

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_LEN; i++) begin
      if (!rst_n)                      lane[i] <= '0;
      else if (we && idx == IW'(i))    lane[i] <= din;
    end
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_out
    assign data[g*8 +: 8] = lane[g];
  end
endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbus_seq_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int TW = 16,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int IW = $clog2(MAX_LEN),
  localparam int DW = MAX_LEN * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [6:0]    req_addr,
  input  logic          req_rd,
  input  logic [7:0]    req_cmd,
  input  logic [2:0]    req_kind,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] tmo_limit,
  input  logic          ev_done,
  input  logic          ev_nack,
  input  logic          ev_berr,
  input  logic          ev_master,
  input  logic [7:0]    eng_rdata,
  output logic          eng_start,
  output logic          eng_stop,
  output logic          eng_nack,
  output logic          eng_wr,
  output logic [7:0]    eng_wdata,
  output logic          done,
  output logic [1:0]    result,
  output logic          reset_req,
  output logic [DW-1:0] rd_data,
  output logic          spurious
);
  st_e           state;
  logic [7:0]    abyte, cmd_q;
  logic [DW-1:0] wbuf;
  logic [LW-1:0] remain, idx;

  logic          legal, via_quick, accept, busy;
  logic [LW-1:0] xlen;
  logic          ev_any, ev_fatal, ev_neg, ev_step, tmo_expire, rx_we;
  logic [DW-1:0] wload;
  logic [7:0]    wlane [MAX_LEN];

  // event classification, error paths take priority over negative ack
  assign ev_any   = ev_done || ev_nack || ev_berr;
  assign ev_fatal = ev_any && (ev_berr || !ev_master);
  assign ev_neg   = ev_any && !ev_fatal && ev_nack;
  assign ev_step  = ev_any && !ev_fatal && !ev_neg;

  assign busy      = (state != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign rx_we     = (state == S_READ) && ev_step;
  assign wload     = (req_kind == 3'(K_BYTE) && !req_rd) ? DW'(req_cmd) : req_wdata;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_wl
    assign wlane[g] = wbuf[g*8 +: 8];
  end

  smbus_seq_req #(.MAX_LEN(MAX_LEN)) u_req (
    .kind(req_kind), .rd(req_rd), .blen(req_len),
    .legal(legal), .xlen(xlen), .via_quick(via_quick)
  );

  smbus_seq_tmr #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(busy), .kick(ev_any),
    .limit(tmo_limit), .expire(tmo_expire)
  );

  smbus_seq_rbuf #(.MAX_LEN(MAX_LEN)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .we(rx_we), .idx(idx[IW-1:0]),
    .din(eng_rdata), .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      abyte <= '0; cmd_q <= '0; wbuf <= '0; remain <= '0; idx <= '0;
      eng_start <= 1'b0; eng_stop <= 1'b0; eng_nack <= 1'b0; eng_wr <= 1'b0;
      eng_wdata <= '0; done <= 1'b0; result <= RES_OK; reset_req <= 1'b0;
      spurious <= 1'b0;
    end else begin
      eng_start <= 1'b0; eng_stop <= 1'b0; eng_wr <= 1'b0;
      done <= 1'b0; reset_req <= 1'b0;
      if (!busy) begin
        if (ev_any) spurious <= 1'b1;
        if (accept) begin
          if (!legal) begin
            done   <= 1'b1;
            result <= RES_INVAL;
          end else begin
            abyte     <= {req_addr, req_rd};
            cmd_q     <= req_cmd;
            wbuf      <= wload;
            remain    <= xlen;
            idx       <= '0;
            eng_start <= 1'b1;
            state     <= via_quick ? S_QUICK : S_ADDR;
          end
        end
      end else if (ev_fatal || tmo_expire) begin
        done <= 1'b1; result <= RES_IOERR; reset_req <= 1'b1; state <= S_IDLE;
      end else if (ev_neg) begin
        eng_stop <= 1'b1; done <= 1'b1; result <= RES_NODEV; state <= S_IDLE;
      end else if (ev_step) begin
        case (state)
          S_ADDR: begin
            eng_wr <= 1'b1; eng_wdata <= {abyte[7:1], 1'b0}; state <= S_CMD;
          end
          S_CMD: begin
            eng_wr <= 1'b1; eng_wdata <= cmd_q;
            state  <= abyte[0] ? S_RSTART : S_WRITE;
          end
          S_RSTART, S_QUICK: begin
            if (state == S_RSTART) eng_start <= 1'b1;
            eng_wr <= 1'b1; eng_wdata <= abyte;
            if (abyte[0]) begin
              eng_nack <= (remain == LW'(1));
              state    <= S_READ;
            end else begin
              state <= S_WRITE;
            end
          end
          S_READ: begin
            eng_nack <= (remain == LW'(2));
            if (remain == LW'(1)) begin
              eng_stop <= 1'b1; done <= 1'b1; result <= RES_OK; state <= S_IDLE;
            end
            idx    <= idx + 1'b1;
            remain <= remain - 1'b1;
          end
          S_WRITE: begin
            if (remain == '0) begin
              eng_stop <= 1'b1; done <= 1'b1; result <= RES_OK; state <= S_IDLE;
            end else begin
              eng_wr <= 1'b1; eng_wdata <= wlane[idx[IW-1:0]];
              idx    <= idx + 1'b1;
              remain <= remain - 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && legal |=> eng_start && !req_ready);
  // R3
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !legal |=> done && result == 2'(RES_INVAL) && !eng_start && req_ready);
  // R7
  rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> idx < LW'(MAX_LEN));
  // R8
  ok_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 2'(RES_OK) |-> eng_stop);
  // R9
  nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_neg |=> eng_stop && done && result == 2'(RES_NODEV) && !reset_req);
  // R10
  fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_fatal |=> done && reset_req && result == 2'(RES_IOERR) && !eng_stop);
  // R11
  tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expire |=> done && reset_req && result == 2'(RES_IOERR));
  // R12
  idle_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ev_any && !req_valid |=> !eng_wr && !eng_stop && !eng_start && spurious);
  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |=> spurious);
endmodule

// File: tb/sim_smbus_seq.sv
`timescale 1ns/1ps
module sim_smbus_seq;
  localparam int MAX_LEN = 32;
  localparam int LW = 6;
  localparam int TW = 16;
  localparam int DW = MAX_LEN * 8;
  localparam int TMO = 12;

  logic clk, rst_n, req_valid, req_ready, req_rd;
  logic [6:0] req_addr;
  logic [7:0] req_cmd, eng_rdata, eng_wdata;
  logic [2:0] req_kind;
  logic [LW-1:0] req_len;
  logic [DW-1:0] req_wdata, rd_data;
  logic [TW-1:0] tmo_limit;
  logic ev_done, ev_nack, ev_berr, ev_master;
  logic eng_start, eng_stop, eng_nack, eng_wr, done, reset_req, spurious;
  logic [1:0] result;

  smbus_seq #(.MAX_LEN(MAX_LEN), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_cmd(req_cmd), .req_kind(req_kind),
    .req_len(req_len), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
    .ev_done(ev_done), .ev_nack(ev_nack), .ev_berr(ev_berr), .ev_master(ev_master),
    .eng_rdata(eng_rdata), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_nack(eng_nack), .eng_wr(eng_wr), .eng_wdata(eng_wdata), .done(done),
    .result(result), .reset_req(reset_req), .rd_data(rd_data), .spurious(spurious)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected per-event steps
  bit         s_wr[48], s_st[48], s_rx[48], s_nc[48], s_nk[48];
  logic [7:0] s_wd[48];
  logic [7:0] rxv[MAX_LEN];
  int         nst;

  task automatic push(bit wr, logic [7:0] wd, bit st, bit rx, bit nc, bit nk);
    s_wr[nst] = wr; s_wd[nst] = wd; s_st[nst] = st;
    s_rx[nst] = rx; s_nc[nst] = nc; s_nk[nst] = nk;
    nst++;
  endtask

  function automatic int bytes_of(input int kind, input int blen);
    if (kind == 0) return 0;
    if (kind == 3) return 2;
    if (kind == 4) return blen;
    return 1;
  endfunction

  task automatic build(input logic [6:0] a, input bit rd, input logic [7:0] cmd,
                       input int kind, input int n, input logic [DW-1:0] wd);
    nst = 0;
    if (kind <= 1) push(1'b1, {a, rd}, 1'b0, 1'b0, rd, n == 1);
    else begin
      push(1'b1, {a, 1'b0}, 1'b0, 1'b0, 1'b0, 1'b0);
      push(1'b1, cmd, 1'b0, 1'b0, 1'b0, 1'b0);
      if (rd) push(1'b1, {a, 1'b1}, 1'b1, 1'b0, 1'b1, n == 1);
    end
    if (rd) begin
      for (int i = 0; i < n; i++) push(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, (n - i) == 2);
    end else begin
      for (int i = 0; i < n; i++)
        push(1'b1, (kind == 1) ? cmd : wd[i*8 +: 8], 1'b0, 1'b0, 1'b0, 1'b0);
      push(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic send_req(input logic [6:0] a, input bit rd, input logic [7:0] cmd,
                          input int kind, input int blen, input logic [DW-1:0] wd);
    req_addr = a; req_rd = rd; req_cmd = cmd; req_kind = 3'(kind);
    req_len = LW'(blen); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_txn(input logic [6:0] a, input bit rd, input logic [7:0] cmd,
                         input int kind, input int blen, input logic [DW-1:0] wd,
                         input int fsel, input int ftype);
    int n, fstep, k;
    string tag;
    n = bytes_of(kind, blen);
    build(a, rd, cmd, kind, n, wd);
    fstep = (ftype == 0) ? -1 : (fsel % nst);
    k = 0;
    send_req(a, rd, cmd, kind, blen, wd);
    chk(eng_start == 1'b1, "R2 start after accept", eng_start, 1);
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    for (int s = 0; s < nst; s++) begin
      if (s == fstep) begin
        case (ftype)
          1: ev_nack = 1'b1;
          2: ev_berr = 1'b1;
          3: begin ev_done = 1'b1; ev_master = 1'b0; end
          5: begin ev_berr = 1'b1; ev_nack = 1'b1; end
          default: ;
        endcase
        if (ftype == 4) repeat (TMO) @(negedge clk);
        else @(negedge clk);
        ev_done = 1'b0; ev_nack = 1'b0; ev_berr = 1'b0; ev_master = 1'b1;
        tag = (ftype == 1) ? "R9" : (ftype == 4) ? "R11" : (ftype == 5) ? "R13" : "R10";
        chk(done == 1'b1, {tag, " done on fault"}, done, 1);
        chk(result == ((ftype == 1) ? 2'd1 : 2'd2), {tag, " result"}, result,
            (ftype == 1) ? 1 : 2);
        chk(reset_req == (ftype != 1), {tag, " reset_req"}, reset_req, ftype != 1);
        chk(eng_stop == (ftype == 1), {tag, " stop"}, eng_stop, ftype == 1);
        return;
      end
      ev_done = 1'b1;
      if (s_rx[s]) begin
        rxv[k] = 8'($urandom);
        eng_rdata = rxv[k];
        k++;
      end
      @(negedge clk);
      ev_done = 1'b0;
      if (s_rx[s]) tag = "R7";
      else if (kind <= 1 && s == 0) tag = "R5";
      else if (kind >= 2 && s < 3) tag = "R4";
      else tag = "R8";
      chk(eng_wr == s_wr[s], {tag, " write strobe"}, eng_wr, s_wr[s]);
      if (s_wr[s]) chk(eng_wdata == s_wd[s], {tag, " written byte"}, eng_wdata, s_wd[s]);
      chk(eng_start == s_st[s], "R4 repeated start", eng_start, s_st[s]);
      if (s_nc[s]) chk(eng_nack == s_nk[s], "R6 ack control", eng_nack, s_nk[s]);
      chk(eng_stop == (s == nst - 1), {tag, " stop"}, eng_stop, s == nst - 1);
      chk(done == (s == nst - 1), {tag, " done"}, done, s == nst - 1);
    end
    chk(result == 2'd0, rd ? "R7 ok result" : "R8 ok result", result, 0);
    if (rd)
      for (int i = 0; i < n; i++)
        chk(rd_data[i*8 +: 8] == rxv[i], "R7 read lane", rd_data[i*8 +: 8], rxv[i]);
  endtask

  task automatic bad_req(input bit rd, input int kind, input int blen);
    send_req(7'h11, rd, 8'h00, kind, blen, '0);
    chk(done == 1'b1, "R3 reject done", done, 1);
    chk(result == 2'd3, "R3 reject result", result, 3);
    chk(eng_start == 1'b0, "R3 no start", eng_start, 0);
    chk(req_ready == 1'b1, "R3 still ready", req_ready, 1);
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] wd;
    int kind, blen, ft;
    bit rd;
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_rd = 1'b0; req_cmd = '0;
    req_kind = '0; req_len = '0; req_wdata = '0; tmo_limit = TW'(TMO);
    ev_done = 1'b0; ev_nack = 1'b0; ev_berr = 1'b0; ev_master = 1'b1; eng_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({eng_start, eng_stop, eng_wr, eng_nack} == 4'b0, "R1 engine strobes",
        {eng_start, eng_stop, eng_wr, eng_nack}, 0);
    chk({done, reset_req, spurious} == 3'b0, "R1 status", {done, reset_req, spurious}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 event while idle
    ev_done = 1'b1;
    @(negedge clk);
    ev_done = 1'b0;
    chk(spurious == 1'b1, "R12 spurious set", spurious, 1);
    chk({eng_wr, eng_stop, eng_start, done} == 4'b0, "R12 no action",
        {eng_wr, eng_stop, eng_start, done}, 0);
    chk(req_ready == 1'b1, "R12 still idle", req_ready, 1);
    repeat (3) @(negedge clk);
    chk(spurious == 1'b1, "R12 spurious sticky", spurious, 1);

    // R3 illegal requests
    bad_req(1'b1, 0, 0);
    bad_req(1'b0, 4, 0);
    bad_req(1'b1, 4, 33);
    bad_req(1'b0, 5, 1);
    bad_req(1'b1, 7, 1);

    // directed transactions
    run_txn(7'h50, 1'b1, 8'h10, 3, 0, '0, 0, 0);           // word read, lane 0 low byte
    run_txn(7'h2A, 1'b1, 8'h33, 2, 0, '0, 0, 0);           // single byte read: NACK at address
    run_txn(7'h48, 1'b0, 8'hC4, 3, 0, rnd_data(), 0, 0);   // word write, low byte first
    run_txn(7'h7F, 1'b0, 8'h01, 4, 32, rnd_data(), 0, 0);  // full block write
    run_txn(7'h01, 1'b1, 8'hFE, 4, 32, '0, 0, 0);          // full block read
    run_txn(7'h3C, 1'b0, 8'h00, 0, 0, '0, 0, 0);           // quick write
    run_txn(7'h3D, 1'b0, 8'h9A, 1, 0, rnd_data(), 0, 0);   // byte write sends command
    run_txn(7'h3E, 1'b1, 8'h00, 1, 0, '0, 0, 0);           // byte read
    run_txn(7'h22, 1'b1, 8'h05, 4, 4, '0, 2, 5);           // R13 berr with nack
    run_txn(7'h23, 1'b0, 8'h06, 2, 0, '0, 0, 1);           // R9 nack on address

    // R11 event in the expiry cycle wins, then a full window runs out
    send_req(7'h21, 1'b0, 8'h5A, 2, 0, '0);
    repeat (TMO - 1) @(negedge clk);
    chk(done == 1'b0, "R11 no early timeout", done, 0);
    ev_done = 1'b1;
    @(negedge clk);
    ev_done = 1'b0;
    chk(done == 1'b0, "R11 event beats timeout", done, 0);
    chk(eng_wr == 1'b1 && eng_wdata == {7'h21, 1'b0}, "R11 step taken", eng_wdata, {7'h21, 1'b0});
    repeat (TMO - 1) @(negedge clk);
    chk(done == 1'b0, "R11 window restarted", done, 0);
    @(negedge clk);
    chk(done == 1'b1 && result == 2'd2 && reset_req == 1'b1, "R11 timeout result",
        {done, result, reset_req}, 4'b1101);

    // random mix
    for (int t = 0; t < 80; t++) begin
      kind = $urandom_range(0, 4);
      rd   = 1'($urandom_range(0, 1));
      if (kind == 0) rd = 1'b0;
      blen = $urandom_range(1, MAX_LEN);
      ft   = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 5) : 0;
      wd   = rnd_data();
      run_txn(7'($urandom), rd, 8'($urandom), kind, blen, wd, $urandom_range(0, 999), ft);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule